// File: doc/BRIEF.md
# I2C byte shifter with address match

This block is the byte-wide serial data path of an I2C peripheral. It holds an 8-bit shift register that a host can load and read back, and an address register that the host can write. Serial data leaves the register from its top bit. Received bits enter at the bottom. The register moves one place left on every rising SCL edge seen in the system clock domain.

SCL and SDA arrive asynchronously and pass through a two-flop synchronizer before rising SCL edges are detected. External logic detects START and STOP conditions and reports each as a one-cycle pulse. After a START, the first complete byte is compared with the stored address. In 7-bit mode only the seven address bits are compared. In 10-bit mode all eight bits are compared, including the stored read/write bit.

A host load of the shift register needs the interface enable. The load zeroes the bit counter. When master mode is also selected, the load produces a pulse that tells the clock generator to start a byte transfer.

Top module: `i2c_byte_shifter`

## Requirements
- R1: `sda_o` always equals bit 7 of the shift register. On each detected SCL rise the register shifts left by one place, so transmission is MSB first.
- R2: On each detected SCL rise the synchronized SDA value enters bit 0. When `scl_i` rises just before clock edge k, `rdata_o` shows the new bit after edge k+2 and not before.
- R3: `sh_wr_i` loads `wdata_i` into the shift register only while `enable_i` is 1; otherwise the load is ignored. `rdata_o` shows the register contents at all times, whatever `enable_i` is.
- R4: An enabled load resets the bit counter to 0. If `master_i` is also 1, `scl_start_o` is 1 for exactly the one cycle after the load edge; otherwise it stays 0.
- R5: `byte_done_o` is high for one cycle, in the cycle after the edge that shifts the 8th bit. The counter then wraps to 0, and the next pulse needs 8 more rises.
- R6: A `start_det_i` pulse resets the bit counter to 0.
- R7: With `ten_bit_i`=0, the first byte completed after a START matches when its bits 7:1 equal `adr_o[7:1]`. Bit 0 is ignored.
- R8: With `ten_bit_i`=1, the first byte after a START matches only when all 8 bits equal `adr_o`, including read/write bit 0.
- R9: `adr_wr_i` loads `wdata_i` into the address register. `stop_det_i` clears `adr_o[0]` to 0 in the next cycle, and this takes priority over a load in the same cycle.
- R10: `addr_match_o` is updated one cycle after the `byte_done_o` pulse of the first byte after a START. Later bytes do not change it. It is cleared by the next START or STOP.
- R11: After reset, all registers and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable; gates host shift register loads |
| master_i | input | 1 | Master mode select |
| ten_bit_i | input | 1 | 1 selects 10-bit address comparison |
| sh_wr_i | input | 1 | Host load strobe for the shift register |
| adr_wr_i | input | 1 | Host load strobe for the address register |
| wdata_i | input | 8 | Host write data |
| scl_i | input | 1 | Raw serial clock |
| sda_i | input | 1 | Raw serial data |
| start_det_i | input | 1 | START or repeated START detected, one-cycle pulse |
| stop_det_i | input | 1 | STOP detected, one-cycle pulse |
| rdata_o | output | 8 | Shift register contents |
| adr_o | output | 8 | Address register contents |
| sda_o | output | 1 | Serial data out (register bit 7) |
| scl_start_o | output | 1 | Request to start master clocking for one byte |
| byte_done_o | output | 1 | Byte complete pulse |
| addr_match_o | output | 1 | First byte after START matched the address |

## Verification
A matching byte is received in 7-bit mode with a different read/write bit. This shows that bit 0 is excluded from the comparison. A mismatching byte shows that a real compare is made and the flag is not just set after a START. In 10-bit mode, bytes that differ only in bit 0 separate the two comparison widths. Repeating one of them after a STOP shows that the stored read/write bit was cleared. A second byte in the same transfer, partial bytes cut off by a START, and host loads with and without enable or master check the byte framing and the gating of the counter and the load.

// File: rtl/i2c_bs_pkg.sv
package i2c_bs_pkg;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned SYNC_STAGES = 2;
  typedef enum logic {ADR_7B = 1'b0, ADR_10B = 1'b1} adr_mode_e;
endpackage

// File: rtl/i2c_bs_sync.sv
module i2c_bs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bs_shreg.sv
module i2c_bs_shreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          cnt_clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        data_o <= load_data_i;
        cnt_q  <= '0;
      end else if (cnt_clr_i) begin
        cnt_q  <= '0;
      end else if (shift_i) begin
        data_o <= {data_o[DW-2:0], bit_i};
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bs_addr.sv
module i2c_bs_addr
  import i2c_bs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  adr_mode_e     mode_i,
  input  logic          byte_done_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] adr_o,
  output logic          match_o
);
  logic pend_q;
  logic cmp;

  always_comb begin
    if (mode_i == ADR_10B) cmp = (byte_i == adr_o);
    else                   cmp = (byte_i[DW-1:1] == adr_o[DW-1:1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_o <= '0;
    end else begin
      if (wr_i) adr_o <= wdata_i;
      if (stop_i) adr_o[0] <= 1'b0; // stop wins over a same-cycle write
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      match_o <= 1'b0;
    end else if (start_i) begin
      pend_q  <= 1'b1;
      match_o <= 1'b0;
    end else if (stop_i) begin
      pend_q  <= 1'b0;
      match_o <= 1'b0;
    end else if (byte_done_i && pend_q) begin
      pend_q  <= 1'b0;
      match_o <= cmp;
    end
  end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_bs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       master_i,
  input  logic       ten_bit_i,
  input  logic       sh_wr_i,
  input  logic       adr_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       start_det_i,
  input  logic       stop_det_i,
  output logic [7:0] rdata_o,
  output logic [7:0] adr_o,
  output logic       sda_o,
  output logic       scl_start_o,
  output logic       byte_done_o,
  output logic       addr_match_o
);
  logic [1:0] pins_s;
  logic       scl_s, sda_s, scl_d, scl_rise;
  logic       load_en;

  i2c_bs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_d <= 1'b0;
    else         scl_d <= scl_s;
  end

  assign scl_rise = scl_s & ~scl_d;
  assign load_en  = sh_wr_i & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_start_o <= 1'b0;
    else         scl_start_o <= load_en & master_i;
  end

  i2c_bs_shreg #(.DW(BYTE_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_data_i(wdata_i),
    .cnt_clr_i  (start_det_i),
    .shift_i    (scl_rise),
    .bit_i      (sda_s),
    .data_o     (rdata_o),
    .done_o     (byte_done_o)
  );

  assign sda_o = rdata_o[BYTE_W-1];

  i2c_bs_addr #(.DW(BYTE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (adr_wr_i),
    .wdata_i    (wdata_i),
    .start_i    (start_det_i),
    .stop_i     (stop_det_i),
    .mode_i     (adr_mode_e'(ten_bit_i)),
    .byte_done_i(byte_done_o),
    .byte_i     (rdata_o),
    .adr_o      (adr_o),
    .match_o    (addr_match_o)
  );
endmodule

// File: rtl/i2c_bs_checker.sv
module i2c_bs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       master_i,
  input logic       sh_wr_i,
  input logic [7:0] wdata_i,
  input logic       start_det_i,
  input logic       stop_det_i,
  input logic       scl_rise,
  input logic       sda_s,
  input logic [7:0] rdata_o,
  input logic [7:0] adr_o,
  input logic       sda_o,
  input logic       scl_start_o,
  input logic       byte_done_o,
  input logic       addr_match_o
);
  AST_SDA_IS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_o == rdata_o[7]); // R1

  AST_RX_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise && !sh_wr_i && !start_det_i |=>
      rdata_o == {$past(rdata_o[6:0]), $past(sda_s)}); // R2

  AST_LOAD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_wr_i && enable_i |=> rdata_o == $past(wdata_i)); // R3

  AST_LOAD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_wr_i && !enable_i && !scl_rise |=> $stable(rdata_o)); // R3

  AST_START_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_start_o |-> $past(sh_wr_i && enable_i && master_i)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o); // R5

  AST_STOP_CLR_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !adr_o[0]); // R9

  AST_MATCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det_i || stop_det_i |=> !addr_match_o); // R10
endmodule

bind i2c_byte_shifter i2c_bs_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .master_i    (master_i),
  .sh_wr_i     (sh_wr_i),
  .wdata_i     (wdata_i),
  .start_det_i (start_det_i),
  .stop_det_i  (stop_det_i),
  .scl_rise    (scl_rise),
  .sda_s       (sda_s),
  .rdata_o     (rdata_o),
  .adr_o       (adr_o),
  .sda_o       (sda_o),
  .scl_start_o (scl_start_o),
  .byte_done_o (byte_done_o),
  .addr_match_o(addr_match_o)
);

// File: tb/tb_i2c_byte_shifter.sv
module tb_i2c_byte_shifter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0, master_i = 1'b0, ten_bit_i = 1'b0;
  logic       sh_wr_i = 1'b0, adr_wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       scl_i = 1'b0, sda_i = 1'b0;
  logic       start_det_i = 1'b0, stop_det_i = 1'b0;
  logic [7:0] rdata_o, adr_o;
  logic       sda_o, scl_start_o, byte_done_o, addr_match_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] data;
    bit         chk_m;
    logic       m;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  i2c_byte_shifter dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk_i); sh_wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i); sh_wr_i = 1'b0;
  endtask

  task automatic adr_wr(input logic [7:0] d);
    @(negedge clk_i); adr_wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i); adr_wr_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_det_i = 1'b1;
    @(negedge clk_i); start_det_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk_i); stop_det_i = 1'b1;
    @(negedge clk_i); stop_det_i = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i); sda_i = b;
    repeat (3) @(negedge clk_i);
    scl_i = 1'b1;
    repeat (4) @(negedge clk_i);
    scl_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit cm, input logic m, input string req);
    item_t it;
    it.data = b; it.chk_m = cm; it.m = m; it.req = req;
    sb_q.push_back(it);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // monitor: compare each completed byte against the scoreboard
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      if (byte_done_o === 1'b1) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5: actual unexpected byte_done data %h expected none", rdata_o);
        end else begin
          it = sb_q.pop_front();
          chk({"R5 byte ", it.req}, rdata_o, it.data);
          if (it.chk_m) begin
            @(negedge clk_i);
            chk(it.req, {7'd0, addr_match_o}, {7'd0, it.m});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 rdata", rdata_o, 8'h00);
    chk("R11 flags", {4'd0, sda_o, scl_start_o, byte_done_o, addr_match_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 adr", adr_o, 8'h00);

    // R3: load ignored while disabled, even with master set
    master_i = 1'b1;
    host_wr(8'h3C);
    chk("R3 disabled load ignored", rdata_o, 8'h00);
    chk("R4 no start when disabled", {7'd0, scl_start_o}, 8'h00);
    master_i = 1'b0;

    // R2 latency
    enable_i = 1'b1;
    host_wr(8'h00);
    sda_i = 1'b1;
    repeat (3) @(negedge clk_i);
    scl_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R2 not yet sampled", rdata_o, 8'h00);
    @(negedge clk_i);
    chk("R2 bit in at k+2", rdata_o, 8'h01);
    scl_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R1 transmit MSB first
    host_wr(8'hA5);
    chk("R3 enabled load", rdata_o, 8'hA5);
    chk("R1 sda is bit7", {7'd0, sda_o}, 8'h01);
    chk("R4 no start without master", {7'd0, scl_start_o}, 8'h00);
    send_bit(1'b0);
    chk("R1 shifted left", rdata_o, 8'h4A);
    chk("R1 sda next bit", {7'd0, sda_o}, 8'h00);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R3 read while disabled", rdata_o, 8'h4A);
    enable_i = 1'b1;

    // R4 load with master: start pulse and counter reset
    master_i = 1'b1;
    host_wr(8'h00);
    chk("R4 start pulse", {7'd0, scl_start_o}, 8'h01);
    @(negedge clk_i);
    chk("R4 start pulse ends", {7'd0, scl_start_o}, 8'h00);
    master_i = 1'b0;
    send_byte(8'hC3, 0, 1'b0, "R4 counter reset");
    send_byte(8'h5A, 0, 1'b0, "R5 counter wrap");

    // R7 7-bit mode
    adr_wr(8'h54);
    chk("R9 adr write", adr_o, 8'h54);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    pulse_start(); // R6 drop partial bits
    send_byte(8'h55, 1, 1'b1, "R7 match ignoring rw");
    send_byte(8'h00, 0, 1'b0, "R10 second byte");
    @(negedge clk_i);
    chk("R10 match held", {7'd0, addr_match_o}, 8'h01);
    pulse_stop();
    chk("R10 stop clears match", {7'd0, addr_match_o}, 8'h00);
    pulse_start();
    send_byte(8'h56, 1, 1'b0, "R7 mismatch");

    // R8 10-bit mode
    ten_bit_i = 1'b1;
    adr_wr(8'hF1);
    pulse_start();
    send_byte(8'hF0, 1, 1'b0, "R8 rw differs");
    pulse_start();
    send_byte(8'hF1, 1, 1'b1, "R8 full match");
    pulse_start();
    chk("R10 start clears match", {7'd0, addr_match_o}, 8'h00);
    pulse_stop();
    chk("R9 stop clears rw", adr_o, 8'hF0);
    pulse_start();
    send_byte(8'hF0, 1, 1'b1, "R8 after rw cleared");
    pulse_stop();

    repeat (20) @(negedge clk_i);
    chk("R5 scoreboard drained", 8'(sb_q.size()), 8'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule